// File: doc/BRIEF.md
# Receive Interrupt and Status Controller

This block sits between the output side of a receive character queue and a host processor. The queue gives a one-cycle strobe each time a new character moves to its head, together with that character's parity-error, overrun and end-of-frame flags. From these the block keeps a character-ready flag and a status word. Parity and overrun errors are held until the host clears them, while the end-of-frame flag describes only the character now at the head. The block also raises a receive interrupt request and selects the special-condition vector.

The host chooses one of four interrupt policies with a two-bit mode input. It can re-arm the first-character policy with a command strobe, and it can clear the held errors with a second strobe. A buffer read or an interrupt acknowledge drops a pending request. Queue storage, interrupt priority chaining and bus timing belong to other blocks.

Top module: `rxi_ctrl`

## Requirements
- R1: Synchronous reset clears the status word, the interrupt request and the vector select, and leaves the first-character policy armed.
- R2: Status bit 0 (ready) is 1 in the cycle after a head strobe. A buffer read clears it. If a read and a head strobe come in the same cycle, the strobe wins.
- R3: Status bit 3 (end of frame) always equals the end-of-frame flag of the most recent head character, and no command clears it.
- R4: Status bit 1 (parity) and bit 2 (overrun) are the OR of all such flags that arrived since the last error-clear strobe. The clear removes older flags, but a flag that arrives in the same cycle as the clear is kept.
- R5: With mode 0 (polling) or mode 3 (reserved, same as polling) no interrupt request is ever raised, while status is still updated.
- R6: With mode 2 (every character), every head strobe raises the request.
- R7: With mode 1 (first character), a head strobe raises the request if the policy is armed. It also raises it if the character is special: held or new overrun, or end of frame. Parity never counts as special in this mode. The first head character disarms the policy. Switching into mode 1 arms it.
- R8: The arm command strobe re-arms mode 1, so that the next head character raises the request.
- R9: In mode 2, a held or new parity error counts as a special condition only when the parity-interrupt enable is 1.
- R10: A raised request stays asserted until a buffer read or an acknowledge. A raise in the same cycle as a read or an acknowledge wins.
- R11: When a head strobe raises the request, the vector select becomes 1 if the status-affects-vector enable is 1 and the character is special, and 0 otherwise. The select is cleared together with the request.
- R12: An error-clear strobe drops the vector select in the same cycle unless the head character carries end of frame, and the select stays low after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_new | input | 1 | A new character reached the queue head this cycle |
| head_par | input | 1 | Parity error of that character |
| head_ovr | input | 1 | Overrun flag of that character |
| head_eof | input | 1 | End-of-frame flag of that character |
| cpu_rd | input | 1 | Host read of the receive buffer |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| irq_mode | input | 2 | 0 polling, 1 first character, 2 every character, 3 polling |
| par_irq_en | input | 1 | Parity counts as special in mode 2 |
| vec_en | input | 1 | Special conditions change the vector |
| cmd_arm | input | 1 | Re-arm first-character policy |
| cmd_err_clr | input | 1 | Clear held parity and overrun errors |
| irq | output | 1 | Receive interrupt request |
| vec_special | output | 1 | Special-condition vector select |
| status | output | 4 | {eof, overrun, parity, ready} |

## Verification
The ready flag, status bits, request and registered vector select all change on the clock edge that samples a strobe, so they are due one cycle after it. The bench drives inputs on the falling edge and compares against its reference model on the next falling edge. The only same-cycle result is the drop of the vector select on an error-clear strobe. That value is also sampled a short delay after the strobe is driven, before any clock edge. Collision cases (read with strobe, clear with strobe, acknowledge with raise) are driven in a single cycle so that their priority shows in the next sample.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
    typedef enum logic [1:0] {
        RXI_POLL  = 2'd0,
        RXI_FIRST = 2'd1,
        RXI_EVERY = 2'd2,
        RXI_RSVD  = 2'd3
    } rxi_mode_e;

    typedef struct packed {
        logic eof;
        logic ovr;
        logic par;
    } rxi_err_t;

    localparam int MODE_W = 2;
    localparam int STAT_W = 4;

    function automatic logic rxi_special(rxi_err_t e, logic par_counts);
        return e.ovr | e.eof | (e.par & par_counts);
    endfunction
endpackage

// File: rtl/rxi_err_latch.sv
module rxi_err_latch
    import rxi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     head_new,
    input  rxi_err_t head_err,
    input  logic     cpu_rd,
    input  logic     err_clr,
    output logic     ready,
    output rxi_err_t err_nx,
    output rxi_err_t err_q
);
    logic ready_q;

    // next view: held errors (unless cleared) merged with the arriving character
    always_comb begin
        err_nx.par = (err_clr ? 1'b0 : err_q.par) | (head_new & head_err.par);
        err_nx.ovr = (err_clr ? 1'b0 : err_q.ovr) | (head_new & head_err.ovr);
        err_nx.eof = head_new ? head_err.eof : err_q.eof;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            err_q <= err_nx;
            if (head_new)    ready_q <= 1'b1;
            else if (cpu_rd) ready_q <= 1'b0;
        end
    end

    assign ready = ready_q;

    AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
        head_new |=> ready_q); // R2
    AST_PAR_HELD: assert property (@(posedge clk) disable iff (rst)
        (err_q.par && !err_clr) |=> err_q.par); // R4
    AST_OVR_HELD: assert property (@(posedge clk) disable iff (rst)
        (err_q.ovr && !err_clr) |=> err_q.ovr); // R4
endmodule

// File: rtl/rxi_irq_ctrl.sv
module rxi_irq_ctrl
    import rxi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      head_new,
    input  rxi_mode_e mode,
    input  logic      par_irq_en,
    input  logic      vec_en,
    input  logic      cmd_arm,
    input  rxi_err_t  err_nx,
    input  logic      eof_now,
    input  logic      cpu_rd,
    input  logic      irq_ack,
    input  logic      err_clr,
    output logic      irq,
    output logic      vec_special
);
    logic      armed_q, armed_eff, entering;
    logic      special, raise, drop;
    logic      irq_q, vec_q;
    rxi_mode_e mode_q;

    assign entering  = (mode == RXI_FIRST) && (mode_q != RXI_FIRST);
    assign armed_eff = armed_q | cmd_arm | entering;
    assign special   = head_new & rxi_special(err_nx, (mode == RXI_EVERY) & par_irq_en);
    assign drop      = cpu_rd | irq_ack;

    always_comb begin
        unique case (mode)
            RXI_EVERY: raise = head_new;
            RXI_FIRST: raise = head_new & (armed_eff | special);
            default:   raise = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            mode_q  <= RXI_POLL;
            irq_q   <= 1'b0;
            vec_q   <= 1'b0;
        end else begin
            mode_q  <= mode;
            armed_q <= (head_new && mode == RXI_FIRST) ? 1'b0 : armed_eff;
            if (raise) begin
                irq_q <= 1'b1;
                vec_q <= vec_en & special;
            end else if (drop) begin
                irq_q <= 1'b0;
                vec_q <= 1'b0;
            end else if (err_clr) begin
                vec_q <= vec_q & err_nx.eof;
            end
        end
    end

    assign irq         = irq_q;
    assign vec_special = vec_q & ~(err_clr & ~eof_now);

    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((mode == RXI_POLL || mode == RXI_RSVD) && !irq_q) |=> !irq_q); // R5
    AST_EVERY_RAISE: assert property (@(posedge clk) disable iff (rst)
        (head_new && mode == RXI_EVERY) |=> irq_q); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !cpu_rd && !irq_ack) |=> irq_q); // R10
    AST_VEC_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        vec_q |-> irq_q); // R11
endmodule

// File: rtl/rxi_ctrl.sv
module rxi_ctrl
    import rxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              head_new,
    input  logic              head_par,
    input  logic              head_ovr,
    input  logic              head_eof,
    input  logic              cpu_rd,
    input  logic              irq_ack,
    input  logic [MODE_W-1:0] irq_mode,
    input  logic              par_irq_en,
    input  logic              vec_en,
    input  logic              cmd_arm,
    input  logic              cmd_err_clr,
    output logic              irq,
    output logic              vec_special,
    output logic [STAT_W-1:0] status
);
    rxi_err_t head_err, err_nx, err_q;
    logic     ready;

    assign head_err = '{eof: head_eof, ovr: head_ovr, par: head_par};

    rxi_err_latch u_err (
        .clk      (clk),
        .rst      (rst),
        .head_new (head_new),
        .head_err (head_err),
        .cpu_rd   (cpu_rd),
        .err_clr  (cmd_err_clr),
        .ready    (ready),
        .err_nx   (err_nx),
        .err_q    (err_q)
    );

    rxi_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .head_new    (head_new),
        .mode        (rxi_mode_e'(irq_mode)),
        .par_irq_en  (par_irq_en),
        .vec_en      (vec_en),
        .cmd_arm     (cmd_arm),
        .err_nx      (err_nx),
        .eof_now     (err_q.eof),
        .cpu_rd      (cpu_rd),
        .irq_ack     (irq_ack),
        .err_clr     (cmd_err_clr),
        .irq         (irq),
        .vec_special (vec_special)
    );

    assign status = {err_q.eof, err_q.ovr, err_q.par, ready};

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq)); // R1
    AST_EOF_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        head_new |=> (status[3] == $past(head_eof))); // R3
endmodule

// File: tb/test_rxi_ctrl.sv
module test_rxi_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic head_new = 0, head_par = 0, head_ovr = 0, head_eof = 0;
    logic cpu_rd = 0, irq_ack = 0, par_irq_en = 0, vec_en = 0;
    logic cmd_arm = 0, cmd_err_clr = 0;
    logic [1:0] irq_mode = 2'd0;
    logic irq, vec_special;
    logic [3:0] status;

    int total = 0, bad = 0;
    string cur_req = "R1";

    // reference model state
    bit m_rdy, m_par, m_ovr, m_eof, m_irq, m_vec, m_arm;
    int m_prev;

    always #2 clk = ~clk;

    rxi_ctrl i_rxi_ctrl (
        .clk(clk), .rst(rst), .head_new(head_new), .head_par(head_par),
        .head_ovr(head_ovr), .head_eof(head_eof), .cpu_rd(cpu_rd),
        .irq_ack(irq_ack), .irq_mode(irq_mode), .par_irq_en(par_irq_en),
        .vec_en(vec_en), .cmd_arm(cmd_arm), .cmd_err_clr(cmd_err_clr),
        .irq(irq), .vec_special(vec_special), .status(status)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_rdy = 0; m_par = 0; m_ovr = 0; m_eof = 0;
            m_irq = 0; m_vec = 0; m_arm = 1; m_prev = 0;
        end else begin
            bit np, no, ne, sp, up, ae;
            int md;
            md = irq_mode;
            np = (cmd_err_clr ? 1'b0 : m_par) | (head_new & head_par);
            no = (cmd_err_clr ? 1'b0 : m_ovr) | (head_new & head_ovr);
            ne = head_new ? head_eof : m_eof;
            sp = head_new & (no | ne | (np & (md == 2) & par_irq_en));
            ae = m_arm | cmd_arm | (md == 1 && m_prev != 1);
            up = head_new & ((md == 2) | ((md == 1) & (ae | sp)));
            if (up) begin m_irq = 1; m_vec = vec_en & sp; end
            else if (cpu_rd | irq_ack) begin m_irq = 0; m_vec = 0; end
            else if (cmd_err_clr) m_vec = m_vec & ne;
            m_arm = (head_new && md == 1) ? 1'b0 : ae;
            m_prev = md;
            if (head_new) m_rdy = 1; else if (cpu_rd) m_rdy = 0;
            m_par = np; m_ovr = no; m_eof = ne;
        end
    end

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit ev;
        ev = m_vec & ~(cmd_err_clr & ~m_eof);
        chk("ready", status[0], m_rdy);
        chk("parity", status[1], m_par);
        chk("overrun", status[2], m_ovr);
        chk("eof", status[3], m_eof);
        chk("irq", irq, m_irq);
        chk("vec", vec_special, ev);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic arrive(bit p, bit o, bit e);
        head_new = 1; head_par = p; head_ovr = o; head_eof = e;
        tick();
        head_new = 0; head_par = 0; head_ovr = 0; head_eof = 0;
    endtask

    task automatic rd();
        cpu_rd = 1; tick(); cpu_rd = 0;
    endtask

    task automatic clr();
        cmd_err_clr = 1; tick(); cmd_err_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        chk("reset status", status, 0);
        chk("reset irq", irq, 0);
        compare_all();

        cur_req = "R2"; irq_mode = 0;
        arrive(0, 0, 0);
        chk("R2 ready set", status[0], 1);
        rd();
        chk("R2 ready cleared", status[0], 0);
        arrive(0, 0, 0);
        cpu_rd = 1; arrive(0, 0, 0); cpu_rd = 0;
        chk("R2 strobe beats read", status[0], 1);
        rd();

        cur_req = "R5";
        arrive(1, 1, 1);
        chk("R5 no irq mode0", irq, 0);
        irq_mode = 3; tick();
        arrive(0, 1, 1);
        chk("R5 no irq mode3", irq, 0);
        clr();

        cur_req = "R3";
        arrive(0, 0, 1);
        chk("R3 eof shown", status[3], 1);
        clr(); rd();
        chk("R3 eof survives clear and read", status[3], 1);
        arrive(0, 0, 0);
        chk("R3 eof follows new char", status[3], 0);

        cur_req = "R4";
        arrive(1, 0, 0);
        arrive(0, 0, 0);
        arrive(0, 1, 0);
        chk("R4 parity held", status[1], 1);
        chk("R4 overrun held", status[2], 1);
        clr();
        chk("R4 cleared", status[2:1], 0);
        cmd_err_clr = 1; arrive(1, 0, 0); cmd_err_clr = 0;
        chk("R4 new flag kept over clear", status[1], 1);
        clr(); rd();

        cur_req = "R6"; irq_mode = 2;
        arrive(0, 0, 0);
        chk("R6 irq every char", irq, 1);
        rd();
        arrive(0, 0, 0);
        chk("R6 irq second char", irq, 1);
        rd();

        cur_req = "R9"; vec_en = 1; par_irq_en = 0;
        arrive(1, 0, 0);
        chk("R9 parity not special", vec_special, 0);
        rd();
        par_irq_en = 1;
        arrive(0, 0, 0);
        chk("R9 held parity special", vec_special, 1);
        rd(); clr();

        cur_req = "R10";
        arrive(0, 0, 0);
        tick(); tick();
        chk("R10 irq held", irq, 1);
        irq_ack = 1; tick(); irq_ack = 0;
        chk("R10 ack drops", irq, 0);
        irq_ack = 1; arrive(0, 0, 0); irq_ack = 0;
        chk("R10 raise beats ack", irq, 1);
        rd();

        cur_req = "R7"; irq_mode = 1; par_irq_en = 1;
        tick();
        arrive(0, 0, 0);
        chk("R7 first char irq", irq, 1);
        rd();
        arrive(0, 0, 0);
        chk("R7 plain char quiet", irq, 0);
        arrive(1, 0, 0);
        chk("R7 parity quiet", irq, 0);
        clr(); rd();
        arrive(0, 1, 0);
        chk("R7 overrun raises", irq, 1);
        chk("R11 vec on special", vec_special, 1);
        rd();
        chk("R11 vec cleared with irq", vec_special, 0);
        arrive(0, 0, 0);
        chk("R7 held overrun raises", irq, 1);
        rd(); clr();
        arrive(0, 0, 1);
        chk("R7 eof raises", irq, 1);
        rd();

        cur_req = "R8";
        arrive(0, 0, 0);
        chk("R8 disarmed quiet", irq, 0);
        cmd_arm = 1; tick(); cmd_arm = 0;
        arrive(0, 0, 0);
        chk("R8 rearmed irq", irq, 1);
        chk("R11 plain vec low", vec_special, 0);
        rd();

        cur_req = "R12";
        arrive(0, 1, 0);
        chk("R12 vec set", vec_special, 1);
        cmd_err_clr = 1; #1;
        chk("R12 same cycle drop", vec_special, 0);
        tick(); cmd_err_clr = 0;
        tick();
        chk("R12 stays low", vec_special, 0);
        chk("R12 irq still up", irq, 1);
        rd();
        arrive(0, 1, 1);
        cmd_err_clr = 1; #1;
        chk("R12 eof keeps vec", vec_special, 1);
        tick(); cmd_err_clr = 0;
        rd();

        cur_req = "R1";
        rst = 1; tick(); rst = 0;
        chk("R1 reset again", status, 0);
        arrive(0, 0, 0);
        chk("R1 armed after reset", irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule